// File: doc/BRIEF.md
# Dual-Width ROM Read Port

This block models the read side of a mask-style read-only memory that can be addressed either as 16-bit words or as 8-bit bytes. A width-select input picks the organisation. In word mode the full 16-bit word at the given address comes out. In byte mode, one extra low-order address input picks either the low or the high half of that word. This input stands for the pin that doubles as data bit 15 in word mode. The array is 512K words. Its contents are not stored: each word is computed from its address, so every read can be predicted.

Two active-low enables gate the output. Chip enable selects the device, and output enable gates data onto the bus. Real tristate pins are replaced by two drive flags, one for the low byte and one for the high byte, and the data bus reads zero whenever a half is not driven. Access times are counted in clock cycles. Address or chip-enable access takes `ADDR_LAT` edges and output-enable access takes `OE_LAT` edges. An active-high identification input switches reads to two fixed code bytes instead of array data.

Top module: `dualwidth_rom_port`

## Requirements
- R1: With `wordMode`=1 and a completed access, `driveLow`=`driveHigh`=1 and `dataOut` equals the array word W(a) = ((a*40503) mod 65536) XOR (a>>3), where a is `addr`.
- R2: With `wordMode`=0, `byteSel`=0 and a completed access, `driveLow`=1, `driveHigh`=0, `dataOut[7:0]`=W(a)[7:0] and `dataOut[15:8]`=0.
- R3: With `wordMode`=0, `byteSel`=1 and a completed access, `dataOut[7:0]`=W(a)[15:8], `dataOut[15:8]`=0 and `driveHigh`=0.
- R4: While `ceN`=1 (standby), both drive flags are 0 and `dataOut` is 0, whatever the level of `oeN`. Reset leaves the port in this idle state.
- R5: While `ceN`=0 and `oeN`=1, both drive flags are 0 and `dataOut` is 0.
- R6: With both enables low, a change of `addr`, of `wordMode`, of `sigMode`, or of `byteSel` in byte mode drops `driveLow` in the same cycle. Data becomes valid again after exactly `ADDR_LAT` (default 4) rising edges, and is not valid after `ADDR_LAT`-1 edges.
- R7: With `addr` stable, when `ceN` falls while `oeN` is low, data becomes valid after exactly `ADDR_LAT` rising edges.
- R8: With chip enable low and the address settled for at least `ADDR_LAT` edges, when `oeN` falls, data becomes valid after exactly `OE_LAT` (default 1) rising edges and not before.
- R9: With `sigMode`=1 and a completed access, the code byte is 0x20 when `addr[0]`=0 and 0xB2 when `addr[0]`=1. In word mode `dataOut` = {0x00, code}. In byte mode `dataOut[7:0]` = code, whatever the value of `byteSel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| wordMode | input | 1 | 1 selects 16-bit words, 0 selects bytes |
| sigMode | input | 1 | 1 selects identification-code reads |
| addr | input | 19 | Word address |
| byteSel | input | 1 | Low-order byte address, used only in byte mode |
| dataOut | output | 16 | Read data, zero in halves that are not driven |
| driveLow | output | 1 | Bits 7:0 are driven with valid data |
| driveHigh | output | 1 | Bits 15:8 are driven with valid data (word mode only) |

## Verification
The bench sweeps a spread of addresses, including both ends of the array, through word, low-byte and high-byte reads. It checks each read one edge before the access completes and again on the edge where it completes. A counter that is off by one would show up as early or late data, and a swapped byte select would return the wrong half. It also changes the address while data is valid, to catch a design that keeps driving stale data. It holds one enable high while the other is low, to catch a gate that uses only one of the two enables. Finally it drops output enable late, after the address has settled, to catch a design that restarts the full address delay for an output-enable event.

// File: rtl/romport_pkg.sv
package romport_pkg;
  typedef struct packed {
    logic driveLow;
    logic driveHigh;
    logic sigSel;
    logic upperSel;
  } strobe_t;

  localparam logic [7:0] MFR_CODE = 8'h20;
  localparam logic [7:0] DEV_CODE = 8'hB2;
  localparam int unsigned HASH_MUL = 40503;
endpackage

// File: rtl/romport_ctrl.sv
module romport_ctrl
  import romport_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int ADDR_LAT = 4,
  parameter int OE_LAT   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              wordMode,
  input  logic              sigMode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              byteSel,
  output strobe_t           strobe
);
  localparam int KEY_W = ADDR_W + 3;
  localparam int AC_W  = $clog2(ADDR_LAT + 1);
  localparam int OC_W  = (OE_LAT < 1) ? 1 : $clog2(OE_LAT + 1);
  localparam logic [AC_W-1:0] A_DONE = AC_W'(ADDR_LAT);
  localparam logic [OC_W-1:0] O_DONE = OC_W'(OE_LAT);

  logic [KEY_W-1:0] accessKey, keyQ;
  logic [AC_W-1:0]  aCnt;
  logic [OC_W-1:0]  oCnt;
  logic             keyChanged, ready;

  // Everything that selects which data comes out; byteSel counts only in byte mode
  assign accessKey  = {sigMode, wordMode, addr, (~wordMode) & byteSel};
  assign keyChanged = (accessKey != keyQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyQ <= '0;
      aCnt <= '0;
      oCnt <= '0;
    end else begin
      keyQ <= accessKey;
      if (ceN)                 aCnt <= '0;
      else if (keyChanged)     aCnt <= AC_W'(1);
      else if (aCnt != A_DONE) aCnt <= aCnt + AC_W'(1);
      if (ceN || oeN)          oCnt <= '0;
      else if (oCnt != O_DONE) oCnt <= oCnt + OC_W'(1);
    end
  end

  assign ready = !ceN && !oeN && !keyChanged && (aCnt == A_DONE) && (oCnt == O_DONE);

  always_comb begin
    strobe.driveLow  = ready;
    strobe.driveHigh = ready && wordMode;
    strobe.sigSel    = sigMode;
    strobe.upperSel  = !wordMode && byteSel;
  end
endmodule

// File: rtl/romport_datapath.sv
module romport_datapath
  import romport_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] addr,
  output logic [15:0]       dataOut
);
  localparam int PROD_W = ADDR_W + 16;

  logic [PROD_W-1:0] prod;
  logic [15:0]       arrayWord;
  logic [7:0]        idCode;
  logic [7:0]        byteVal;
  logic [15:0]       fullWord;

  // Array content is a fixed function of the address instead of stored bits
  assign prod      = PROD_W'(addr) * PROD_W'(HASH_MUL);
  assign arrayWord = prod[15:0] ^ 16'(addr >> 3);
  assign idCode    = addr[0] ? DEV_CODE : MFR_CODE;

  always_comb begin
    fullWord = strobe.sigSel ? {8'h00, idCode} : arrayWord;
    if (strobe.sigSel)        byteVal = idCode;
    else if (strobe.upperSel) byteVal = arrayWord[15:8];
    else                      byteVal = arrayWord[7:0];

    dataOut = '0;
    if (strobe.driveHigh)     dataOut = fullWord;
    else if (strobe.driveLow) dataOut = {8'h00, byteVal};
  end
endmodule

// File: rtl/dualwidth_rom_port.sv
module dualwidth_rom_port
  import romport_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int ADDR_LAT = 4,
  parameter int OE_LAT   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              wordMode,
  input  logic              sigMode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              byteSel,
  output logic [15:0]       dataOut,
  output logic              driveLow,
  output logic              driveHigh
);
  strobe_t strobe;

  romport_ctrl #(.ADDR_W(ADDR_W), .ADDR_LAT(ADDR_LAT), .OE_LAT(OE_LAT)) ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .wordMode(wordMode),
    .sigMode(sigMode), .addr(addr), .byteSel(byteSel), .strobe(strobe)
  );

  romport_datapath #(.ADDR_W(ADDR_W)) dpath (
    .strobe(strobe), .addr(addr), .dataOut(dataOut)
  );

  assign driveLow  = strobe.driveLow;
  assign driveHigh = strobe.driveHigh;
endmodule

// File: rtl/romport_chk.sv
module romport_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rstN,
  input logic              ceN,
  input logic              oeN,
  input logic              wordMode,
  input logic              sigMode,
  input logic [ADDR_W-1:0] addr,
  input logic              byteSel,
  input logic [15:0]       dataOut,
  input logic              driveLow,
  input logic              driveHigh
);
  // R4
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ceN |-> (!driveLow && !driveHigh));

  // R4
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !driveLow |-> (dataOut == 16'h0000));

  // R5
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> (!driveLow && !driveHigh));

  // R1
  high_needs_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    driveHigh |-> (wordMode && driveLow));

  // R2
  byte_narrow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wordMode |-> (!driveHigh && dataOut[15:8] == 8'h00));

  // R6
  settle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(driveLow) |-> (!$past(ceN) && $past(addr) == addr && $past(wordMode) == wordMode));

  // R9
  sig_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (driveLow && sigMode) |-> (dataOut[7:0] == (addr[0] ? 8'hB2 : 8'h20)));
endmodule

bind dualwidth_rom_port romport_chk #(.ADDR_W(ADDR_W)) chk (.*);

// File: tb/dualwidth_rom_port_test.sv
module dualwidth_rom_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int ALAT = 4;
  localparam int OLAT = 1;

  logic        clk = 0;
  logic        rstN, ceN, oeN, wordMode, sigMode, byteSel;
  logic [18:0] addr;
  logic [15:0] dataOut;
  logic        driveLow, driveHigh;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dualwidth_rom_port #(.ADDR_W(19), .ADDR_LAT(ALAT), .OE_LAT(OLAT)) uut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .wordMode(wordMode),
    .sigMode(sigMode), .addr(addr), .byteSel(byteSel),
    .dataOut(dataOut), .driveLow(driveLow), .driveHigh(driveHigh)
  );

  function automatic logic [15:0] expWord(input int a);
    longint p;
    p = longint'(a) * 40503;
    return 16'(p & 16'hFFFF) ^ 16'(a >> 3);
  endfunction

  function automatic logic [15:0] expRead(input int a, input bit wm, input bit lsb, input bit sg);
    logic [15:0] w;
    logic [7:0]  code;
    code = (a & 1) ? 8'hB2 : 8'h20;
    if (sg) return {8'h00, code};
    w = expWord(a);
    if (wm) return w;
    return lsb ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkIdle(input string req);
    check(!driveLow && !driveHigh && dataOut == 16'h0, req,
          {13'b0, driveLow, driveHigh, 1'b0} ^ 32'(dataOut), 32'h0);
  endtask

  // Called at a negedge; applies inputs and checks one edge early and on time
  task automatic doRead(input int a, input bit wm, input bit lsb, input bit sg, input string req);
    logic [15:0] e;
    addr = 19'(a); wordMode = wm; byteSel = lsb; sigMode = sg;
    ceN = 0; oeN = 0;
    e = expRead(a, wm, lsb, sg);
    #1;
    check(!driveLow, {req, "/R6 drop on change"}, 32'(driveLow), 32'h0);
    repeat (ALAT-1) @(posedge clk);
    @(negedge clk);
    check(!driveLow, {req, "/R6 early"}, 32'(driveLow), 32'h0);
    @(posedge clk);
    @(negedge clk);
    check(driveLow && (driveHigh == wm) && dataOut == e, req,
          {14'b0, driveLow, driveHigh, dataOut}, {14'b0, 1'b1, wm, e});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 0; ceN = 1; oeN = 1; wordMode = 1; sigMode = 0; byteSel = 0; addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkIdle("R4 reset");
    rstN = 1;

    // Sweep: word, low byte, high byte at each address
    for (int i = 0; i < 96; i++) begin
      int a;
      if (i == 0) a = 0;
      else if (i == 1) a = 19'h7FFFF;
      else a = (i * 5471 + 17) % 524288;
      doRead(a, 1'b1, 1'b0, 1'b0, "R1 word");
      doRead(a, 1'b0, 1'b0, 1'b0, "R2 byte low");
      doRead(a, 1'b0, 1'b1, 1'b0, "R3 byte high");
    end

    // Signature codes
    doRead(0, 1'b1, 1'b0, 1'b1, "R9 sig word mfr");
    doRead(1, 1'b1, 1'b0, 1'b1, "R9 sig word dev");
    doRead(0, 1'b0, 1'b1, 1'b1, "R9 sig byte mfr");
    doRead(1, 1'b0, 1'b1, 1'b1, "R9 sig byte dev");
    doRead(1, 1'b0, 1'b1, 1'b0, "R9 leave sig");

    // Output disable then late output enable
    doRead(12345, 1'b1, 1'b0, 1'b0, "R1 pre-disable");
    oeN = 1;
    for (int k = 0; k < 6; k++) begin
      #1;
      checkIdle("R5 output disable");
      @(negedge clk);
    end
    oeN = 0;
    #1;
    check(!driveLow, "R8 not before edge", 32'(driveLow), 32'h0);
    repeat (OLAT) @(posedge clk);
    @(negedge clk);
    check(driveLow && dataOut == expWord(12345), "R8 oe access",
          {15'b0, driveLow, dataOut}, {15'b0, 1'b1, expWord(12345)});

    // Standby with output enable low
    ceN = 1;
    for (int k = 0; k < 6; k++) begin
      #1;
      checkIdle("R4 standby");
      @(negedge clk);
    end
    // Chip enable falls with address stable
    ceN = 0;
    repeat (ALAT-1) @(posedge clk);
    @(negedge clk);
    check(!driveLow, "R7 early", 32'(driveLow), 32'h0);
    @(posedge clk);
    @(negedge clk);
    check(driveLow && dataOut == expWord(12345), "R7 ce access",
          {15'b0, driveLow, dataOut}, {15'b0, 1'b1, expWord(12345)});

    // Address change while valid in byte mode via byteSel alone
    doRead(777, 1'b0, 1'b0, 1'b0, "R2 before toggle");
    doRead(777, 1'b0, 1'b1, 1'b0, "R6 byteSel restart");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule